// File: doc/BRIEF.md
# Receive Serial Clock Generator

This block produces the receive-side clocks of an audio serial port: a high-frequency master clock and a receive bit clock. Each comes from its own stage. A stage either divides its source by a programmable ratio or passes an external pin through. Each stage can also invert its output. The high-frequency stage divides an auxiliary clock input. The bit stage divides the selected high-frequency clock, taken before its polarity inversion. Pin output-enable flags show which clocks the block drives.

All logic runs on one system clock `clk`. Every clock source (auxiliary clock, external pins, transmit bit clock) is a level that the block samples on `clk`. A divider counts rising edges of its sampled source. When the synchronous-mode flag `async_i` is low, the receive clock output follows the transmit generator's bit clock. In that mode the local bit stage does not drive the output.

Two control registers are loaded through a plain write port: `wr_sel_i` 0 selects the bit-clock register and 1 selects the high-clock register. Both registers and all counters clear on reset.

Top module: `rclk_gen`

## Requirements
- R1: After reset, `hclk_o`, `rclk_o`, `hclk_oe_o` and `rclk_oe_o` are 0. Both stages start with external source, ratio field 0 and no inversion.
- R2: A write with `wr_sel_i`=0 loads the bit-clock register: ratio field [4:0], internal-source flag [5], invert flag [7]. A write with `wr_sel_i`=1 loads the high-clock register: ratio field [11:0], invert flag [14], internal-source flag [15]. The new values act from the next cycle. A write to one register leaves the other unchanged.
- R3: With the high stage internal, `hclk_o` divides the rising edges of `aux_clk_i` by field+1. With field 0, `hclk_o` repeats `aux_clk_i` two cycles later.
- R4: For an even ratio N≥2 the divided clock is high for N/2 source periods and low for N/2. For an odd ratio it is high for (N-1)/2 and low for (N+1)/2. Each period starts with the high phase.
- R5: With the bit stage internal, its source is the selected high-frequency clock before inversion, registered once. It divides that source by field+1 in the same way as R3 and R4.
- R6: A stage in external mode puts its pin (`hclk_pin_i` or `bclk_pin_i`) on its output one cycle later.
- R7: The invert flag of a stage inverts that stage's output in both internal and external mode.
- R8: While `async_i` is 0, `rclk_o` equals `tx_bclk_i` one cycle later, whatever the bit-stage settings. While `async_i` is 1, `rclk_o` comes from the bit stage.
- R9: Any write to a control register clears that stage's edge counter in the same edge. The next output period therefore starts at once with the high phase of the new ratio.
- R10: `hclk_oe_o` is the high stage's internal-source flag delayed by one cycle. `rclk_oe_o` is the bit stage's internal-source flag ANDed with `async_i`, delayed by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Control register write strobe |
| wr_sel_i | input | 1 | 0 = bit-clock register, 1 = high-clock register |
| wr_data_i | input | 16 | Write data |
| aux_clk_i | input | 1 | Auxiliary clock level, source of the high divider |
| hclk_pin_i | input | 1 | External high-frequency clock pin level |
| bclk_pin_i | input | 1 | External bit clock pin level |
| tx_bclk_i | input | 1 | Transmit generator bit clock level |
| async_i | input | 1 | 1 = receive runs on its own chain, 0 = borrow transmit clock |
| hclk_o | output | 1 | High-frequency receive clock |
| hclk_oe_o | output | 1 | Drive enable for the high-frequency pin |
| rclk_o | output | 1 | Receive bit clock |
| rclk_oe_o | output | 1 | Drive enable for the bit clock pin |

## Verification
The auxiliary clock is driven two ways. A clean toggle every cycle makes every period and duty cycle regular, so an off-by-one in the ratio or in the high/low split shows at once. Random levels make rising edges arrive at irregular times, which tests that the dividers count edges and not cycles. Ratios 1, 2, 3, 4 and 7 are run on the high stage and 1, 2 and 3 on the bit stage, with the high stage at ratio 2, so that pass-through, even and odd splits, and the two-stage chain can each be told apart. Random pin and transmit-clock levels are applied in external and synchronous modes, with and without inversion. Rewrites in the middle of a period check that the counter restarts.

// File: rtl/rclk_pkg.sv
package rclk_pkg;
  localparam int CTRL_W      = 16;
  localparam int BDIV_BITS   = 5;
  localparam int HDIV_BITS   = 12;
  // field positions of the bit-clock control register
  localparam int B_INT_POS   = 5;
  localparam int B_INV_POS   = 7;
  // field positions of the high-clock control register
  localparam int H_INV_POS   = 14;
  localparam int H_INT_POS   = 15;
endpackage

// File: rtl/rclk_ctrl_regs.sv
module rclk_ctrl_regs
  import rclk_pkg::*;
#(
  parameter int REG_W  = CTRL_W,
  parameter int BDIV_W = BDIV_BITS,
  parameter int HDIV_W = HDIV_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [BDIV_W-1:0] b_div_o,
  output logic              b_int_o,
  output logic              b_inv_o,
  output logic [HDIV_W-1:0] h_div_o,
  output logic              h_int_o,
  output logic              h_inv_o,
  output logic              b_restart_o,
  output logic              h_restart_o
);
  logic b_wr, h_wr;
  assign b_wr = wr_en_i && !wr_sel_i;
  assign h_wr = wr_en_i &&  wr_sel_i;
  assign b_restart_o = b_wr;
  assign h_restart_o = h_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      b_div_o <= '0;
      b_int_o <= 1'b0;
      b_inv_o <= 1'b0;
      h_div_o <= '0;
      h_int_o <= 1'b0;
      h_inv_o <= 1'b0;
    end else begin
      if (b_wr) begin
        b_div_o <= wr_data_i[BDIV_W-1:0];
        b_int_o <= wr_data_i[B_INT_POS];
        b_inv_o <= wr_data_i[B_INV_POS];
      end
      if (h_wr) begin
        h_div_o <= wr_data_i[HDIV_W-1:0];
        h_int_o <= wr_data_i[H_INT_POS];
        h_inv_o <= wr_data_i[H_INV_POS];
      end
    end
  end

  AST_BIT_WR_LOAD: assert property (@(posedge clk) disable iff (rst)
    b_wr |=> (b_div_o == $past(wr_data_i[BDIV_W-1:0]))); // R2
  AST_HIGH_WR_KEEPS_BIT: assert property (@(posedge clk) disable iff (rst)
    h_wr |=> ($stable(b_div_o) && $stable(b_int_o) && $stable(b_inv_o))); // R2
  AST_BIT_WR_KEEPS_HIGH: assert property (@(posedge clk) disable iff (rst)
    b_wr |=> ($stable(h_div_o) && $stable(h_int_o) && $stable(h_inv_o))); // R2
endmodule

// File: rtl/rclk_div_stage.sv
module rclk_div_stage #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] ratio_m1_i,
  input  logic             int_en_i,
  input  logic             inv_en_i,
  input  logic             src_i,
  input  logic             ext_i,
  input  logic             ovr_en_i,
  input  logic             ovr_i,
  output logic             raw_o,
  output logic             out_o
);
  localparam int HALF_W = DIV_W + 1;

  logic             src_d;
  logic [DIV_W-1:0] cnt;
  logic             rise;
  logic [HALF_W-1:0] half;
  logic             div_lvl;
  logic             sel;

  assign rise    = src_i && !src_d;
  assign half    = HALF_W'(({1'b0, ratio_m1_i} + HALF_W'(1)) >> 1);
  assign div_lvl = (ratio_m1_i == '0) ? src_d : ({1'b0, cnt} < half);
  assign sel     = int_en_i ? div_lvl : ext_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_d <= 1'b0;
      cnt   <= '0;
      raw_o <= 1'b0;
      out_o <= 1'b0;
    end else begin
      src_d <= src_i;
      if (restart_i)
        cnt <= '0;
      else if (rise)
        cnt <= (cnt == ratio_m1_i) ? '0 : cnt + 1'b1;
      raw_o <= sel;
      out_o <= ovr_en_i ? ovr_i : (sel ^ inv_en_i);
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= ratio_m1_i); // R3
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (cnt == '0)); // R9
  AST_EXT_PASS: assert property (@(posedge clk) disable iff (rst)
    !int_en_i |=> (raw_o == $past(ext_i))); // R6
  AST_OVERRIDE_PASS: assert property (@(posedge clk) disable iff (rst)
    ovr_en_i |=> (out_o == $past(ovr_i))); // R8
endmodule

// File: rtl/rclk_gen.sv
module rclk_gen
  import rclk_pkg::*;
#(
  parameter int REG_W  = CTRL_W,
  parameter int BDIV_W = BDIV_BITS,
  parameter int HDIV_W = HDIV_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             aux_clk_i,
  input  logic             hclk_pin_i,
  input  logic             bclk_pin_i,
  input  logic             tx_bclk_i,
  input  logic             async_i,
  output logic             hclk_o,
  output logic             hclk_oe_o,
  output logic             rclk_o,
  output logic             rclk_oe_o
);
  logic [BDIV_W-1:0] b_div;
  logic [HDIV_W-1:0] h_div;
  logic b_int, b_inv, h_int, h_inv, b_rst, h_rst;
  logic h_raw, b_raw;

  rclk_ctrl_regs #(.REG_W(REG_W), .BDIV_W(BDIV_W), .HDIV_W(HDIV_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i),
    .b_div_o(b_div), .b_int_o(b_int), .b_inv_o(b_inv),
    .h_div_o(h_div), .h_int_o(h_int), .h_inv_o(h_inv),
    .b_restart_o(b_rst), .h_restart_o(h_rst)
  );

  rclk_div_stage #(.DIV_W(HDIV_W)) u_high (
    .clk(clk), .rst(rst), .restart_i(h_rst), .ratio_m1_i(h_div),
    .int_en_i(h_int), .inv_en_i(h_inv), .src_i(aux_clk_i),
    .ext_i(hclk_pin_i), .ovr_en_i(1'b0), .ovr_i(1'b0),
    .raw_o(h_raw), .out_o(hclk_o)
  );

  rclk_div_stage #(.DIV_W(BDIV_W)) u_bit (
    .clk(clk), .rst(rst), .restart_i(b_rst), .ratio_m1_i(b_div),
    .int_en_i(b_int), .inv_en_i(b_inv), .src_i(h_raw),
    .ext_i(bclk_pin_i), .ovr_en_i(!async_i), .ovr_i(tx_bclk_i),
    .raw_o(b_raw), .out_o(rclk_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hclk_oe_o <= 1'b0;
      rclk_oe_o <= 1'b0;
    end else begin
      hclk_oe_o <= h_int;
      rclk_oe_o <= b_int && async_i;
    end
  end

  AST_HIGH_POLARITY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (hclk_o == (h_raw ^ $past(h_inv)))); // R7
  AST_BIT_POLARITY: assert property (@(posedge clk) disable iff (rst)
    async_i |=> (rclk_o == (b_raw ^ $past(b_inv)))); // R7
  AST_SYNC_BORROW: assert property (@(posedge clk) disable iff (rst)
    !async_i |=> (rclk_o == $past(tx_bclk_i))); // R8
  AST_OE_SYNC_LOW: assert property (@(posedge clk) disable iff (rst)
    !async_i |=> !rclk_oe_o); // R10
endmodule

// File: tb/test_rclk_gen.sv
module test_rclk_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic aux = 1'b0, hpin = 1'b0, bpin = 1'b0, txb = 1'b0, asy = 1'b1;
  logic hclk, hoe, rclk, roe;

  int checks = 0, fails = 0;
  string req = "R1";
  bit cmp_on = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rclk_gen i_rclk_gen (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .aux_clk_i(aux), .hclk_pin_i(hpin),
    .bclk_pin_i(bpin), .tx_bclk_i(txb), .async_i(asy),
    .hclk_o(hclk), .hclk_oe_o(hoe), .rclk_o(rclk), .rclk_oe_o(roe)
  );

  // behavioural reference
  int  mh_div, mb_div;
  bit  mh_int, mh_inv, mb_int, mb_inv;
  bit  mh_sd, mb_sd, mh_raw;
  int  mh_cnt, mb_cnt;
  bit  m_hclk, m_rclk, m_hoe, m_roe;

  always @(posedge clk) begin
    int hr, br, nh, nb;
    bit hs, bs, hl, bl;
    if (rst) begin
      mh_div = 0; mb_div = 0; mh_int = 0; mh_inv = 0; mb_int = 0; mb_inv = 0;
      mh_sd = 0; mb_sd = 0; mh_raw = 0; mh_cnt = 0; mb_cnt = 0;
      m_hclk = 0; m_rclk = 0; m_hoe = 0; m_roe = 0;
    end else begin
      hr = mh_div + 1;
      br = mb_div + 1;
      hl = (hr == 1) ? mh_sd : (mh_cnt < hr / 2);
      bl = (br == 1) ? mb_sd : (mb_cnt < br / 2);
      hs = mh_int ? hl : hpin;
      bs = mb_int ? bl : bpin;
      nh = (aux && !mh_sd) ? ((mh_cnt == hr - 1) ? 0 : mh_cnt + 1) : mh_cnt;
      nb = (mh_raw && !mb_sd) ? ((mb_cnt == br - 1) ? 0 : mb_cnt + 1) : mb_cnt;
      m_hoe  = mh_int;
      m_roe  = mb_int && asy;
      m_hclk = hs ^ mh_inv;
      m_rclk = asy ? (bs ^ mb_inv) : txb;
      mb_sd  = mh_raw;
      mh_sd  = aux;
      mh_raw = hs;
      if (wr_en && !wr_sel) begin
        nb = 0; mb_div = int'(wr_data[4:0]); mb_int = wr_data[5]; mb_inv = wr_data[7];
      end
      if (wr_en && wr_sel) begin
        nh = 0; mh_div = int'(wr_data[11:0]); mh_inv = wr_data[14]; mh_int = wr_data[15];
      end
      mh_cnt = nh;
      mb_cnt = nb;
    end
  end

  task automatic check(input string what, input logic act, input bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check("hclk_o", hclk, m_hclk);
      check("rclk_o", rclk, m_rclk);
      check("hclk_oe_o", hoe, m_hoe);
      check("rclk_oe_o", roe, m_roe);
    end
  end

  task automatic wr(input bit sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    aux = ~aux;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // mode 0: aux toggles each cycle; mode 1: random aux
  task automatic run(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      aux  = (mode == 0) ? ~aux : 1'($urandom);
      hpin = 1'($urandom);
      bpin = 1'($urandom);
      txb  = 1'($urandom);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    req = "R1";
    check("hclk_o reset", hclk, 1'b0);
    check("rclk_o reset", rclk, 1'b0);
    check("hclk_oe_o reset", hoe, 1'b0);
    check("rclk_oe_o reset", roe, 1'b0);
    rst = 1'b0;
    cmp_on = 1;
    run(20, 1);

    req = "R6"; run(100, 1);
    req = "R7"; wr(1, 16'h4000); wr(0, 16'h0080); run(100, 1);
    req = "R2"; wr(1, 16'h0000); wr(0, 16'h0000); run(20, 1);

    req = "R3";
    for (int r = 0; r < 4; r++) begin
      wr(1, 16'h8000 | 16'(r)); run(80, 0); run(80, 1);
    end
    req = "R4";
    wr(1, 16'h8006); run(120, 0);
    wr(1, 16'h8003); run(120, 0);

    req = "R5";
    wr(1, 16'h8001);
    for (int r = 0; r < 3; r++) begin
      wr(0, 16'h0020 | 16'(r)); run(150, 0); run(100, 1);
    end
    req = "R7"; wr(1, 16'hC001); wr(0, 16'h00A2); run(150, 0);

    req = "R8"; asy = 1'b0; run(120, 1);
    wr(0, 16'h0023); run(40, 0);
    asy = 1'b1; run(60, 0);

    req = "R9";
    for (int k = 0; k < 6; k++) begin
      run(3 + k, 0); wr(1, 16'h8003); run(5, 0); wr(0, 16'h0022);
    end
    run(80, 0);

    req = "R10";
    wr(1, 16'h0002); wr(0, 16'h0001); run(20, 1);
    wr(0, 16'h0021); asy = 1'b0; run(10, 1); asy = 1'b1; run(20, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule